// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of a single-wire, open-drain serial bus. The bus has an external pullup. The controller starts every activity on the line. It produces the initialization pulse and listens for a slave's answer. It also produces one-bit time slots that write a one, write a zero, or read a bit back. The line is presented as two signals: an active-high pull-low enable (`drive_low_o`) and the line level as seen by the block (`line_i`). The controller never drives the line high.

A host selects an operation on `cmd_op` and pulses `cmd_start` while the block is idle. `busy_o` rises with the accepted command. Every operation runs for a fixed number of clock cycles. A one-cycle `done_o` pulse follows it. After an initialization, `presence_o` reports whether a slave pulled the line low at the configured sampling instant. After a read slot, `rd_bit_o` holds the level sampled at the read instant.

All durations are cycle-count parameters. The initialization low time includes an extra term that compensates for a slow falling edge. The line input passes through a two-flop synchronizer, so each sample reflects the line level two cycles earlier.

Top module: `swb_master`

## Requirements
- R1: With operation code 2'b00 (initialization), `drive_low_o` is high for exactly T_RSTL+T_FCOMP cycles. These start with the first cycle in which `busy_o` is high.
- R2: An initialization lasts T_RSTL+T_FCOMP+T_RSTH busy cycles. `presence_o` becomes 1 if the line was low two cycles before busy cycle index T_RSTL+T_FCOMP+T_MSP (index 0 is the first busy cycle). Otherwise it becomes 0.
- R3: With operation code 2'b11 (write one), `drive_low_o` is high for exactly T_W1L cycles and the slot lasts T_SLOT+T_REC busy cycles.
- R4: With operation code 2'b10 (write zero), `drive_low_o` is high for exactly T_W0L cycles, without a gap, and the slot lasts T_SLOT+T_REC busy cycles.
- R5: With operation code 2'b01 (read), `drive_low_o` is high for exactly T_RL cycles and the slot lasts T_SLOT+T_REC busy cycles. `rd_bit_o` takes the line level present two cycles before busy cycle index T_MSR.
- R6: A `cmd_start` that arrives while `busy_o` is high is ignored. The running operation keeps its timing, and no further operation or `done_o` pulse results from it.
- R7: `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls. Within one operation, `drive_low_o` is never asserted again once it has been released, and it is never high while `busy_o` is low.
- R8: `presence_o` changes only when an initialization samples it. `rd_bit_o` changes only when a read slot samples it.
- R9: After reset, `busy_o`, `done_o`, `drive_low_o`, `presence_o` and `rd_bit_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all durations count its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_start | input | 1 | Start strobe, accepted only while idle |
| cmd_op | input | 2 | Operation: 00 init, 01 read, 10 write zero, 11 write one |
| busy_o | output | 1 | High for every cycle of an accepted operation |
| done_o | output | 1 | One-cycle pulse after an operation ends |
| presence_o | output | 1 | Slave answered the last initialization |
| rd_bit_o | output | 1 | Bit sampled by the last read slot |
| line_i | input | 1 | Level of the open-drain bus line |
| drive_low_o | output | 1 | Pull-low enable for the bus line driver |

## Verification
The end of one operation and the acceptance of the next can fall in the same cycle. While `done_o` pulses, `busy_o` is already low, so a start strobe raised in that cycle is taken. The bench waits for an initialization's done pulse and raises a read command in that same cycle. It then checks three things: the presence result survives, the read slot runs its full low time and length, and exactly one further done pulse follows. A start issued in the middle of a write-zero slot is also checked, and it must leave that slot's low time and length unchanged.

// File: rtl/swb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the single-wire bus master.
// Assumes the two-bit operation code seen at the top-level port.
package swb_pkg;

    typedef enum logic [1:0] {
        OP_INIT = 2'b00,
        OP_READ = 2'b01,
        OP_WR0  = 2'b10,
        OP_WR1  = 2'b11
    } swb_op_e;

endpackage

// File: rtl/swb_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for the asynchronous bus line level.
// Assumes STAGES >= 2. Resets to the idle (pulled-up) level.
module swb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shreg;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];

endmodule

// File: rtl/swb_slot_timer.sv
`timescale 1ns/1ps
// Cycle counter for one bus operation. A load starts it at index 0,
// and it stops itself after the cycle whose index is len-1.
// Assumes len >= 1 and that load is only raised while inactive.
module swb_slot_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          active,
    output logic [CW-1:0] count,
    output logic          last
);

    assign last = active && (count == len - CW'(1));

    // Run state and position within the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            count  <= '0;
        end else if (load) begin
            active <= 1'b1;
            count  <= '0;
        end else if (last) begin
            active <= 1'b0;
            count  <= '0;
        end else if (active) begin
            count  <= count + CW'(1);
        end
    end

endmodule

// File: rtl/swb_master.sv
`timescale 1ns/1ps
// Master controller for a single open-drain bus line with an external pullup.
// It runs one fixed-length operation per accepted command: an initialization
// pulse with a presence sample, or a one-bit write or read slot.
// Assumes: all T_* values are clock cycles; T_MSR < T_SLOT+T_REC;
// T_RSTL+T_FCOMP+T_MSP < total init length. Sample indices include
// the two-cycle line synchronizer latency.
module swb_master
    import swb_pkg::*;
#(
    parameter int T_RSTL  = 480,
    parameter int T_FCOMP = 2,
    parameter int T_RSTH  = 480,
    parameter int T_MSP   = 70,
    parameter int T_W1L   = 6,
    parameter int T_W0L   = 60,
    parameter int T_RL    = 6,
    parameter int T_MSR   = 12,
    parameter int T_SLOT  = 70,
    parameter int T_REC   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic [1:0] cmd_op,
    output logic       busy_o,
    output logic       done_o,
    output logic       presence_o,
    output logic       rd_bit_o,
    input  logic       line_i,
    output logic       drive_low_o
);

    localparam int INIT_LOW   = T_RSTL + T_FCOMP;
    localparam int INIT_TOTAL = INIT_LOW + T_RSTH;
    localparam int INIT_SAMP  = INIT_LOW + T_MSP;
    localparam int BIT_TOTAL  = T_SLOT + T_REC;
    localparam int MAX_TOTAL  = (INIT_TOTAL > BIT_TOTAL) ? INIT_TOTAL : BIT_TOTAL;
    localparam int CW         = $clog2(MAX_TOTAL + 1);

    swb_op_e       op_q;
    logic          accept;
    logic          active;
    logic          last;
    logic [CW-1:0] count;
    logic [CW-1:0] low_len;
    logic [CW-1:0] total_len;
    logic          line_s;
    logic          done_q;
    logic          pres_q;
    logic          rd_q;

    assign accept = cmd_start && !active;

    swb_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_i),
        .q     (line_s)
    );

    swb_slot_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .len    (total_len),
        .active (active),
        .count  (count),
        .last   (last)
    );

    // Latch the operation code when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      op_q <= OP_INIT;
        else if (accept) op_q <= swb_op_e'(cmd_op);
    end

    // Pick the low time and slot length of the latched operation.
    always_comb begin
        case (op_q)
            OP_INIT: begin low_len = CW'(INIT_LOW); total_len = CW'(INIT_TOTAL); end
            OP_WR1:  begin low_len = CW'(T_W1L);    total_len = CW'(BIT_TOTAL);  end
            OP_WR0:  begin low_len = CW'(T_W0L);    total_len = CW'(BIT_TOTAL);  end
            default: begin low_len = CW'(T_RL);     total_len = CW'(BIT_TOTAL);  end
        endcase
    end

    // Issue the done pulse in the cycle after the last busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last;
    end

    // Capture the presence answer at the configured instant of an initialization.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pres_q <= 1'b0;
        else if (active && op_q == OP_INIT && count == CW'(INIT_SAMP))
            pres_q <= !line_s;
    end

    // Capture the read bit at the configured instant of a read slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= 1'b0;
        else if (active && op_q == OP_READ && count == CW'(T_MSR))
            rd_q <= line_s;
    end

    assign drive_low_o = active && (count < low_len);
    assign busy_o      = active;
    assign done_o      = done_q;
    assign presence_o  = pres_q;
    assign rd_bit_o    = rd_q;

endmodule

// File: rtl/swb_master_chk.sv
`timescale 1ns/1ps
// Temporal checks on the port behaviour of swb_master, attached by bind.
// Assumes the reset is synchronous and active low.
module swb_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       busy_o,
    input logic       done_o,
    input logic       presence_o,
    input logic       rd_bit_o,
    input logic       drive_low_o
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                         // R7

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));                      // R7

    AST_NO_IDLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !drive_low_o);                                   // R7

    AST_NO_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !drive_low_o) |=> !drive_low_o);                  // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_start && !drive_low_o) |=> !drive_low_o);     // R6

    AST_PRES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(presence_o));                            // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(rd_bit_o));                              // R8

endmodule

bind swb_master swb_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .presence_o  (presence_o),
    .rd_bit_o    (rd_bit_o),
    .drive_low_o (drive_low_o)
);

// File: tb/sim_swb_master.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected results, a monitor
// measures each operation at the ports and compares on done.
module sim_swb_master;

    localparam int P_RSTL = 20, P_FCOMP = 3, P_RSTH = 24, P_MSP = 8;
    localparam int P_W1L = 2, P_W0L = 10, P_RL = 2, P_MSR = 6;
    localparam int P_SLOT = 14, P_REC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       busy_o, done_o, presence_o, rd_bit_o, drive_low_o;
    logic       slave_pull = 1'b0;
    wire        line_i = !(drive_low_o || slave_pull);

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    low;
        int    total;
        logic  pres;
        logic  rd;
        string tag;
        string ptag;
        string rtag;
    } exp_t;

    exp_t q[$];
    logic m_pres = 1'b0;
    logic m_rd   = 1'b0;
    int   dones  = 0;
    int   pushes = 0;

    swb_master #(
        .T_RSTL(P_RSTL), .T_FCOMP(P_FCOMP), .T_RSTH(P_RSTH), .T_MSP(P_MSP),
        .T_W1L(P_W1L), .T_W0L(P_W0L), .T_RL(P_RL), .T_MSR(P_MSR),
        .T_SLOT(P_SLOT), .T_REC(P_REC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .busy_o(busy_o), .done_o(done_o), .presence_o(presence_o),
        .rd_bit_o(rd_bit_o), .line_i(line_i), .drive_low_o(drive_low_o)
    );

    always #2.5 clk = !clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Build the expected item for one operation from the requirements.
    task automatic push(input logic [1:0] op, input logic pull);
        exp_t e;
        case (op)
            2'b00: begin e.low = P_RSTL + P_FCOMP; e.total = P_RSTL + P_FCOMP + P_RSTH;
                         e.tag = "R1"; m_pres = pull; end
            2'b11: begin e.low = P_W1L; e.total = P_SLOT + P_REC; e.tag = "R3"; end
            2'b10: begin e.low = P_W0L; e.total = P_SLOT + P_REC; e.tag = "R4"; end
            default: begin e.low = P_RL; e.total = P_SLOT + P_REC; e.tag = "R5";
                         m_rd = !pull; end
        endcase
        e.ptag = (op == 2'b00) ? "R2" : "R8";
        e.rtag = (op == 2'b01) ? "R5" : "R8";
        e.pres = m_pres;
        e.rd   = m_rd;
        q.push_back(e);
        pushes++;
    endtask

    task automatic start_now(input logic [1:0] op, input logic pull);
        push(op, pull);
        cmd_op     = op;
        slave_pull = pull;
        cmd_start  = 1'b1;
        @(negedge clk);
        cmd_start  = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic pull);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_now(op, pull);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        slave_pull = 1'b0;
    endtask

    // Monitor: measure busy and low lengths, compare on each done pulse.
    int   busy_cnt = 0, low_cnt = 0;
    logic released = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                dones++;
                if (prev_done) chk("R7", "done pulse width", 2, 1);
                if (q.size() == 0) begin
                    chk("R6", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, "busy cycles", busy_cnt, e.total);
                    chk(e.tag, "low cycles", low_cnt, e.low);
                    chk(e.ptag, "presence", int'(presence_o), int'(e.pres));
                    chk(e.rtag, "read bit", int'(rd_bit_o), int'(e.rd));
                end
                busy_cnt = 0; low_cnt = 0; released = 1'b0;
            end
            if (busy_o) begin
                busy_cnt++;
                if (drive_low_o) begin
                    if (released) chk("R7", "drive after release", 1, 0);
                    low_cnt++;
                end else begin
                    released = 1'b1;
                end
            end else if (drive_low_o) begin
                chk("R7", "drive while idle", 1, 0);
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "busy after reset", int'(busy_o), 0);
        chk("R9", "done after reset", int'(done_o), 0);
        chk("R9", "drive after reset", int'(drive_low_o), 0);
        chk("R9", "presence after reset", int'(presence_o), 0);
        chk("R9", "read bit after reset", int'(rd_bit_o), 0);

        issue(2'b00, 1'b1); wait_done();          // R1 R2 slave answers
        issue(2'b11, 1'b0); wait_done();          // R3
        issue(2'b01, 1'b0); wait_done();          // R5 reads 1
        issue(2'b10, 1'b1);                       // R4 with R6 stray start
        repeat (3) @(negedge clk);
        cmd_op = 2'b01; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done();
        issue(2'b01, 1'b1); wait_done();          // R5 reads 0
        issue(2'b00, 1'b0); wait_done();          // R2 no slave, R8 read bit held
        issue(2'b00, 1'b1); wait_done();          // init then read in done cycle
        start_now(2'b01, 1'b0); wait_done();      // R5 R8 back to back

        repeat (40) @(negedge clk);
        chk("R6", "operations completed", dones, pushes);
        chk("R6", "scoreboard empty", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule